// File: doc/BRIEF.md
# Upset Shift-Chain Tester

This block checks a long chain of flip-flops for single-event upsets while it sits in a radiation beam. Each run starts with a `start` pulse. A stimulus generator then feeds a known bit stream into the chain: either a square wave or a PRBS-7 sequence, chosen by `mode`. A second, identical generator trails the first by exactly the chain depth. It supplies the bit that should be leaving the chain in each cycle. Each disagreement between that expected bit and the chain's serial output adds one to an error tally.

The tally is held in three redundant copies. Every cycle the copies are resolved bit by bit by majority vote, and the voted value, plus any new error, is written back into all three. A single disturbed copy therefore heals on the next clock edge.

A run lasts a fixed number of clock cycles, set by a parameter. The default is three minutes at 240 MHz. The run then stops by itself, raises `done`, and keeps the final voted tally on `error_count` until the next `start`. The chain's serial output is also brought out. An `upset_in` input flips the bit entering the chain, so that a known number of faults can be placed in the stream.

Top module: `seu_chain_tester`

## Requirements
- R1: After reset, `done` is 0, `error_count` is 0 and `chain_out` is 0.
- R2: A `start` pulse clears the tally, the run timer and `done`, and latches `mode`, even in the middle of a run. In the cycle after the start edge (run cycle 0), `error_count` reads 0.
- R3: When `mode`=0, the stimulus bit of run cycle j is j mod 2, so the stream begins with 0.
- R4: When `mode`=1, the stimulus is PRBS-7 with polynomial x^7+x^6+1. The 7-bit state starts at 7'b1111110 and the output bit is state[6]. Each step shifts the state left and moves state[6]^state[5] into state[0].
- R5: The chain has CHAIN_LEN stages. In run cycle k, `chain_out` equals the stimulus bit of run cycle k-CHAIN_LEN XOR the `upset_in` value of that cycle.
- R6: Comparison covers only run cycles CHAIN_LEN through RUN_CYCLES-1. An upset applied in run cycle RUN_CYCLES-CHAIN_LEN or later is never counted.
- R7: Each mismatch raises `error_count` by exactly one. The new value is visible in the cycle after the mismatch.
- R8: `error_count` saturates at 2^CNT_W-1 and does not wrap.
- R9: The tally is kept in three copies. They are combined by bitwise majority, and all three are written with the same voted next value on every edge.
- R10: A run has exactly RUN_CYCLES active cycles. `done` is 0 in run cycle RUN_CYCLES-1 and 1 from run cycle RUN_CYCLES until the next `start`.
- R11: Outside an active run, `upset_in` has no effect: the chain holds still and `error_count` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) a run |
| mode | input | 1 | Stimulus select: 0 square wave, 1 PRBS-7 |
| upset_in | input | 1 | Inverts the bit entering the chain this cycle |
| chain_out | output | 1 | Serial output of the last chain stage |
| done | output | 1 | Run finished |
| error_count | output | CNT_W | Majority-voted mismatch tally |

## Verification
The hardest cases to reach from the ports are mismatches that fall exactly on the edges of the comparison window, and a tally that reaches saturation. Without a fault source, a correct chain never mismatches at all. The bench uses `upset_in` to place bursts of inverted bits at chosen run cycles: at cycle 0, astride the cut-off at RUN_CYCLES-CHAIN_LEN, and long enough to pass 2^CNT_W-1 in a small configuration. It then compares the final tally with the count of in-window upsets. A restart part-way through a run with upsets already counted shows that `start` discards the old tally.

// File: rtl/seu_tester_pkg.sv
package seu_tester_pkg;

    typedef enum logic {
        PAT_SQUARE = 1'b0,
        PAT_PRBS7  = 1'b1
    } pat_mode_e;

    localparam logic [6:0] PAT_SEED = 7'b1111110;

    // Next generator state for the chosen pattern.
    function automatic logic [6:0] pat_next(input pat_mode_e m, input logic [6:0] s);
        if (m == PAT_PRBS7) begin
            return {s[5:0], s[6] ^ s[5]};
        end
        return {s[6:1], ~s[0]};
    endfunction

    // Bit presented by a generator state.
    function automatic logic pat_out(input pat_mode_e m, input logic [6:0] s);
        return (m == PAT_PRBS7) ? s[6] : s[0];
    endfunction

endpackage

// File: rtl/seu_pattern_gen.sv
module seu_pattern_gen
    import seu_tester_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      adv,
    input  pat_mode_e mode,
    output logic      bit_o
);

    typedef struct packed {
        logic [6:0] lfsr;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (load) begin
            gen_d.lfsr = PAT_SEED;
        end else if (adv) begin
            gen_d.lfsr = pat_next(mode, gen_q.lfsr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '{lfsr: PAT_SEED};
        end else begin
            gen_q <= gen_d;
        end
    end

    assign bit_o = pat_out(mode, gen_q.lfsr);

    // R4: the PRBS register never locks up in the all-zero state
    p_prbs_alive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PAT_PRBS7) |-> (gen_q.lfsr != 7'd0));

    // R3: the square wave changes on every step
    p_square_toggles_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && mode == PAT_SQUARE) |=> (bit_o != $past(bit_o)));

endmodule

// File: rtl/seu_shift_chain.sv
module seu_shift_chain #(
    parameter int unsigned LEN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic [LEN-1:0] bits;
    } chain_t;

    chain_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (shift) begin
            ch_d.bits = {ch_q.bits[LEN-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign dout = ch_q.bits[LEN-1];

    // R11: a halted chain keeps its output
    p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(dout));

    // R5: the head stage captures the incoming bit
    p_head_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (ch_q.bits[0] == $past(din)));

endmodule

// File: rtl/seu_run_timer.sv
module seu_run_timer #(
    parameter int unsigned     RUN_W      = 36,
    parameter longint unsigned RUN_CYCLES = 64'd43_200_000_000,
    parameter int unsigned     FILL       = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic compare_en,
    output logic done
);

    localparam logic [RUN_W-1:0] LAST   = RUN_W'(RUN_CYCLES - 64'd1);
    localparam logic [RUN_W-1:0] FILL_V = RUN_W'(FILL);

    typedef struct packed {
        logic [RUN_W-1:0] elapsed;
        logic             running;
        logic             finished;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (start) begin
            tm_d.elapsed  = '0;
            tm_d.running  = 1'b1;
            tm_d.finished = 1'b0;
        end else if (tm_q.running) begin
            if (tm_q.elapsed == LAST) begin
                tm_d.running  = 1'b0;
                tm_d.finished = 1'b1;
            end else begin
                tm_d.elapsed = tm_q.elapsed + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign active     = tm_q.running;
    assign compare_en = tm_q.running && (tm_q.elapsed >= FILL_V);
    assign done       = tm_q.finished;

    // R10: a run is never both active and finished
    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && done));

    // R10: done stays up until a new start
    p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R10: done only rises at the end of a run
    p_done_after_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(active));

    // R6: comparison is only ever enabled inside an active run
    p_window_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
        compare_en |-> active);

endmodule

// File: rtl/seu_tmr_counter.sv
module seu_tmr_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count_o
);

    localparam int unsigned  COPIES = 3;
    localparam logic [W-1:0] MAX    = '1;

    typedef struct packed {
        logic [COPIES-1:0][W-1:0] copy;
    } cnt_t;

    cnt_t cn_d, cn_q;
    logic [W-1:0] voted;
    logic [W-1:0] next_val;

    always_comb begin
        voted = (cn_q.copy[0] & cn_q.copy[1])
              | (cn_q.copy[0] & cn_q.copy[2])
              | (cn_q.copy[1] & cn_q.copy[2]);
        if (clear) begin
            next_val = '0;
        end else if (inc && (voted != MAX)) begin
            next_val = voted + 1'b1;
        end else begin
            next_val = voted;
        end
    end

    for (genvar i = 0; i < COPIES; i++) begin : g_copy
        always_comb begin
            cn_d.copy[i] = next_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cn_q <= '0;
        end else begin
            cn_q <= cn_d;
        end
    end

    assign count_o = voted;

    // R9: all copies agree after every write-back
    p_copies_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cn_q.copy[0] == cn_q.copy[1]) && (cn_q.copy[1] == cn_q.copy[2]));

    // R7: the tally moves by at most one per cycle
    p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)));

    // R7: an error below the ceiling is always counted
    p_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && inc && count_o != MAX) |=> (count_o == $past(count_o) + 1'b1));

    // R8: a full tally stays full
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && count_o == MAX) |=> (count_o == MAX));

    // R2: clearing empties the tally
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_o == '0));

endmodule

// File: rtl/seu_chain_tester.sv
module seu_chain_tester
    import seu_tester_pkg::*;
#(
    parameter int unsigned     CHAIN_LEN  = 256,
    parameter int unsigned     CNT_W      = 32,
    parameter int unsigned     RUN_W      = 36,
    parameter longint unsigned RUN_CYCLES = 64'd43_200_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic             upset_in,
    output logic             chain_out,
    output logic             done,
    output logic [CNT_W-1:0] error_count
);

    typedef struct packed {
        pat_mode_e mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic active, compare_en;
    logic lead_bit, twin_bit;
    logic step_lead, step_twin, mismatch;

    always_comb begin
        cfg_d = cfg_q;
        if (start) begin
            cfg_d.mode = pat_mode_e'(mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: PAT_SQUARE};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign step_lead = active && !start;
    assign step_twin = compare_en && !start;
    assign mismatch  = step_twin && (chain_out != twin_bit);

    seu_run_timer #(
        .RUN_W      (RUN_W),
        .RUN_CYCLES (RUN_CYCLES),
        .FILL       (CHAIN_LEN)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .active     (active),
        .compare_en (compare_en),
        .done       (done)
    );

    seu_pattern_gen u_lead (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .adv   (step_lead),
        .mode  (cfg_q.mode),
        .bit_o (lead_bit)
    );

    seu_pattern_gen u_twin (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .adv   (step_twin),
        .mode  (cfg_q.mode),
        .bit_o (twin_bit)
    );

    seu_shift_chain #(
        .LEN (CHAIN_LEN)
    ) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (step_lead),
        .din   (lead_bit ^ upset_in),
        .dout  (chain_out)
    );

    seu_tmr_counter #(
        .W (CNT_W)
    ) u_errs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .inc     (mismatch),
        .count_o (error_count)
    );

    // R11: the tally is frozen while no run is active
    p_idle_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> $stable(error_count));

    // R6: the expected stream only advances inside the window
    p_twin_lags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_twin |-> step_lead);

endmodule

// File: tb/seu_chain_tester_test.sv
module seu_chain_tester_test;

    localparam int unsigned N    = 8;
    localparam int unsigned CW   = 4;
    localparam int          RUN  = 100;
    localparam int          SATV = (1 << CW) - 1;

    // Scenario table: mode, first upset cycle, upset length, expected tally
    localparam int NSC = 6;
    localparam int SC_MODE [NSC] = '{0, 1, 1, 0, 1, 0};
    localparam int SC_AT   [NSC] = '{0, 10, 20, 90, 0, 30};
    localparam int SC_LEN  [NSC] = '{0, 1, 5, 5, 3, 20};
    localparam int SC_EXP  [NSC] = '{0, 1, 5, 2, 3, SATV};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic upset_in = 1'b0;
    logic chain_out;
    logic done;
    logic [CW-1:0] error_count;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    seu_chain_tester #(
        .CHAIN_LEN  (N),
        .CNT_W      (CW),
        .RUN_W      (36),
        .RUN_CYCLES (64'(RUN))
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode        (mode),
        .upset_in    (upset_in),
        .chain_out   (chain_out),
        .done        (done),
        .error_count (error_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit pat_model(input int md, input int j);
        logic [6:0] s;
        if (md == 0) return bit'(j % 2);
        s = 7'b1111110;
        for (int i = 0; i < j; i++) s = {s[5:0], s[6] ^ s[5]};
        return s[6];
    endfunction

    // Called at a falling edge; returns at the falling edge of run cycle 0.
    task automatic kick(input int md);
        mode  = md[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_scn(input int md, input int ua, input int ul, input int ex, input int abort_at);
        kick(md);
        for (int c = 0; c <= RUN; c++) begin
            bit up;
            if (c == abort_at) begin
                upset_in = 1'b0;
                return;
            end
            if (c == 0) begin
                chk(error_count == 0, "R2 tally cleared", error_count, 0);
                chk(done == 1'b0, "R2 done cleared", done, 0);
            end
            if (c >= N && c < N + 16) begin
                int j = c - N;
                bit e = pat_model(md, j) ^ ((j >= ua && j < ua + ul) ? 1'b1 : 1'b0);
                chk(chain_out == e, (md == 0) ? "R3/R5 chain bit" : "R4/R5 chain bit",
                    chain_out, e);
            end
            if (c == RUN - 1) chk(done == 1'b0, "R10 done low in last cycle", done, 0);
            if (c == RUN) begin
                chk(done == 1'b1, "R10 done high", done, 1);
                chk(error_count == ex, "R6/R7/R8 final tally", error_count, ex);
            end
            up = (c >= ua && c < ua + ul);
            upset_in = up;
            @(negedge clk);
        end
        upset_in = 1'b0;
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(error_count == 0, "R1 tally", error_count, 0);
        chk(chain_out == 1'b0, "R1 chain", chain_out, 0);

        // R11: upsets before any run are ignored
        upset_in = 1'b1;
        repeat (N + 2) @(negedge clk);
        upset_in = 1'b0;
        chk(chain_out == 1'b0, "R11 idle chain", chain_out, 0);
        chk(error_count == 0, "R11 idle tally", error_count, 0);

        for (int s = 0; s < NSC; s++) begin
            run_scn(SC_MODE[s], SC_AT[s], SC_LEN[s], SC_EXP[s], -1);
        end

        // R11: after done, upsets change nothing
        begin
            logic held = chain_out;
            upset_in = 1'b1;
            repeat (12) begin
                @(negedge clk);
                chk(chain_out == held, "R11 chain frozen after done", chain_out, held);
            end
            upset_in = 1'b0;
            chk(error_count == SATV, "R11 tally frozen after done", error_count, SATV);
            chk(done == 1'b1, "R10 done held", done, 1);
        end

        // R2: restart mid-run with errors already counted
        run_scn(1, 10, 3, 0, 40);
        chk(error_count == 3, "R7 tally before restart", error_count, 3);
        run_scn(0, 0, 0, 0, -1);

        // R2: restart in PRBS mode after a square-wave run, mode relatched
        run_scn(1, 50, 2, 2, -1);

        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

endmodule